// File: doc/BRIEF.md
# Advance-Tick Time Base Selector

This block produces a one-cycle advance tick for a pattern address counter, all within a single system clock domain. The tick is drawn from one of three time bases. The first is an external accelerator clock. It can be counted on its rising or its falling edge, and it can be divided by 1, 2 or 4. The second is an on-board oscillator. The third is a step bit in the control register, which lets software advance the counter one position at a time.

The external clock, the oscillator and a beam-crossing pulse all arrive asynchronously. Each one is resynchronised and reduced to a single-cycle edge event. A beam-crossing edge can restart the divider so that the divided phase lines up with the crossing. An activity monitor decides whether the external clock is running. In automatic mode the block follows the external clock while it runs and falls back to the oscillator when it stops.

Software writes a 4-bit control word. The current source is reported on a status output, so the user can see which time base drives the tick.

Top module: `tick_source_sel`

## Requirements
- R1: While reset is asserted and after it is released, `tick_o` is 0, `src_o` is 00 (step source), `ext_ok_o` is 0 and `ctrl_rdata_o` is 0000.
- R2: A write (`ctrl_we_i`=1) stores `ctrl_wdata_i`, and `ctrl_rdata_o` returns it. Bit 0 selects the oscillator, bit 1 selects the external clock, bit 2 counts the external clock on falling edges, and bit 3 is the step bit.
- R3: With bits[1:0]=00, a tick occurs one cycle after a write that takes bit 3 from 0 to 1. Any other write gives no tick, and `src_o` is 00.
- R4: With bits[1:0]=01, every rising edge of `osc_clk_i` gives one tick. External clock edges give none, and `src_o` is 01.
- R5: With bits[1:0]=10, external clock edges, after division, give the ticks. Oscillator edges give none, and `src_o` is 10. A level change on an asynchronous input appears on `tick_o` after three clock edges.
- R6: `psc_ratio_i` 00 ticks on every counted external edge. 01 ticks on every 2nd edge and 10 or 11 on every 4th edge, counted from the last divider clear.
- R7: When `bx_clr_en_i`=1, a rising edge of the synchronised `bx_i` clears the divider count. When `bx_clr_en_i`=0, `bx_i` has no effect.
- R8: With bit 2 set, external falling edges are counted and rising edges are not.
- R9: With bits[1:0]=11, the external clock drives the tick (`src_o`=10) while `ext_ok_o`=1. Otherwise the oscillator drives it (`src_o`=01).
- R10: `ext_ok_o` drops after IDLE_LIMIT clocks with no counted external edge. It rises on the REVIVE-th edge of a run in which no gap reaches IDLE_LIMIT clocks. The edge that revives it does not tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 4 | Control write data |
| ctrl_rdata_o | output | 4 | Control register contents |
| ext_clk_i | input | 1 | External accelerator clock (asynchronous) |
| osc_clk_i | input | 1 | On-board oscillator (asynchronous) |
| psc_ratio_i | input | 2 | External divider ratio code |
| bx_i | input | 1 | Beam-crossing pulse (asynchronous) |
| bx_clr_en_i | input | 1 | Allows beam crossings to clear the divider |
| tick_o | output | 1 | One-cycle advance tick |
| src_o | output | 2 | Source driving the tick: 00 step, 01 oscillator, 10 external |
| ext_ok_o | output | 1 | External clock judged running |

## Verification
The tick selection is tried with bursts of pulses on the selected source and on the unselected one. This shows that each mode listens to one time base only. Divider runs start from a beam-crossing clear and use ratios 1, 2 and 4. A short burst after a clear, and another burst with the clear disabled, separate a real restart from an ignored one. In automatic mode, the bench uses a dead external clock, a burst long enough to revive it, a pause long enough to kill it, and two short runs split by a long gap. Together these cover the failover, the fallback and the consecutive-edge rule.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

  typedef enum logic [1:0] {
    SRC_STEP = 2'b00,
    SRC_OSC  = 2'b01,
    SRC_EXT  = 2'b10
  } src_e;

  // Control word: bit3 step, bit2 falling edge, bit1 external, bit0 oscillator
  typedef struct packed {
    logic step;
    logic ext_fall;
    logic use_ext;
    logic use_osc;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tsel_edge_sync.sv
module tsel_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  input  logic fall_i,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q, sync_n;
  logic              last_q, last_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], async_i};
    last_n = sync_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_n;
      last_q <= last_n;
    end
  end

  assign edge_o = fall_i ? (~sync_q[STAGES-1] &  last_q)
                         : ( sync_q[STAGES-1] & ~last_q);

endmodule

// File: rtl/tsel_prescaler.sv
module tsel_prescaler #(
  parameter int unsigned CNT_W = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       edge_i,
  input  logic       clr_i,
  input  logic [1:0] ratio_i,
  output logic       tick_o
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             hit;

  always_comb begin
    cnt_n = cnt_q;
    if (clr_i)       cnt_n = '0;
    else if (edge_i) cnt_n = cnt_q + 1'b1;
  end

  always_comb begin
    unique case (ratio_i)
      2'b00:   hit = 1'b1;
      2'b01:   hit = cnt_q[0];
      default: hit = &cnt_q[1:0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_n;
  end

  assign tick_o = edge_i & ~clr_i & hit;

endmodule

// File: rtl/tsel_activity_mon.sv
module tsel_activity_mon #(
  parameter int unsigned IDLE_LIMIT = 16,
  parameter int unsigned REVIVE     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic alive_o
);

  localparam int unsigned IW = $clog2(IDLE_LIMIT + 1);
  localparam int unsigned RW = $clog2(REVIVE + 1);

  logic [IW-1:0] idle_q, idle_n;
  logic [RW-1:0] run_q, run_n;
  logic          alive_q, alive_n;
  logic          timeout;

  always_comb begin
    idle_n  = idle_q;
    run_n   = run_q;
    alive_n = alive_q;
    timeout = ~edge_i & (idle_q == IW'(IDLE_LIMIT - 1));

    if (edge_i)                          idle_n = '0;
    else if (idle_q != IW'(IDLE_LIMIT))  idle_n = idle_q + 1'b1;

    if (alive_q) begin
      run_n = '0;
      if (timeout) alive_n = 1'b0;
    end else if (edge_i) begin
      if (run_q == RW'(REVIVE - 1)) begin
        alive_n = 1'b1;
        run_n   = '0;
      end else begin
        run_n = run_q + 1'b1;
      end
    end else if (timeout) begin
      run_n = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q  <= '0;
      run_q   <= '0;
      alive_q <= 1'b0;
    end else begin
      idle_q  <= idle_n;
      run_q   <= run_n;
      alive_q <= alive_n;
    end
  end

  assign alive_o = alive_q;

endmodule

// File: rtl/tick_source_sel.sv
module tick_source_sel
  import tsel_pkg::*;
#(
  parameter int unsigned IDLE_LIMIT  = 16,
  parameter int unsigned REVIVE      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  input  logic              ext_clk_i,
  input  logic              osc_clk_i,
  input  logic [1:0]        psc_ratio_i,
  input  logic              bx_i,
  input  logic              bx_clr_en_i,
  output logic              tick_o,
  output logic [1:0]        src_o,
  output logic              ext_ok_o
);

  ctrl_t ctrl_q, ctrl_n;
  src_e  src_q, src_n;
  logic  tick_q, tick_n;

  logic ext_edge, osc_edge, bx_edge;
  logic ext_tick, ext_alive, step_hit;

  tsel_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .async_i (ext_clk_i),
    .fall_i (ctrl_q.ext_fall), .edge_o (ext_edge)
  );

  tsel_edge_sync #(.STAGES(SYNC_STAGES)) u_osc_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .async_i (osc_clk_i),
    .fall_i (1'b0), .edge_o (osc_edge)
  );

  tsel_edge_sync #(.STAGES(SYNC_STAGES)) u_bx_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .async_i (bx_i),
    .fall_i (1'b0), .edge_o (bx_edge)
  );

  tsel_prescaler #(.CNT_W(2)) u_psc (
    .clk_i (clk_i), .rst_ni (rst_ni), .edge_i (ext_edge),
    .clr_i (bx_edge & bx_clr_en_i), .ratio_i (psc_ratio_i),
    .tick_o (ext_tick)
  );

  tsel_activity_mon #(.IDLE_LIMIT(IDLE_LIMIT), .REVIVE(REVIVE)) u_mon (
    .clk_i (clk_i), .rst_ni (rst_ni), .edge_i (ext_edge),
    .alive_o (ext_alive)
  );

  // Step fires on a write that raises the step bit
  assign step_hit = ctrl_we_i & ctrl_wdata_i[CTRL_W-1] & ~ctrl_q.step;

  always_comb begin
    ctrl_n = ctrl_q;
    if (ctrl_we_i) ctrl_n = ctrl_t'(ctrl_wdata_i);
  end

  always_comb begin
    unique case ({ctrl_q.use_ext, ctrl_q.use_osc})
      2'b00:   src_n = SRC_STEP;
      2'b01:   src_n = SRC_OSC;
      2'b10:   src_n = SRC_EXT;
      default: src_n = ext_alive ? SRC_EXT : SRC_OSC;
    endcase
  end

  always_comb begin
    unique case (src_n)
      SRC_STEP: tick_n = step_hit;
      SRC_OSC:  tick_n = osc_edge;
      SRC_EXT:  tick_n = ext_tick;
      default:  tick_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      src_q  <= SRC_STEP;
      tick_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      src_q  <= src_n;
      tick_q <= tick_n;
    end
  end

  assign ctrl_rdata_o = ctrl_q;
  assign src_o        = src_q;
  assign tick_o       = tick_q;
  assign ext_ok_o     = ext_alive;

endmodule

// File: rtl/tick_source_sel_chk.sv
module tick_source_sel_chk
  import tsel_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       step_i,
  input logic       tick_o,
  input logic [1:0] src_o,
  input logic       ext_ok_o
);

  // R1
  legal_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_o != 2'b11);

  // R3
  step_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> (src_o == SRC_STEP));

  // R3
  step_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && src_o == SRC_STEP) |-> (step_i && !$past(step_i)));

  // R4
  osc_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01) |=> (src_o == SRC_OSC));

  // R5
  ext_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10) |=> (src_o == SRC_EXT));

  // R9
  auto_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && ext_ok_o) |=> (src_o == SRC_EXT));

  // R9
  auto_osc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && !ext_ok_o) |=> (src_o == SRC_OSC));

endmodule

bind tick_source_sel tick_source_sel_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (ctrl_rdata_o[1:0]),
  .step_i   (ctrl_rdata_o[3]),
  .tick_o   (tick_o),
  .src_o    (src_o),
  .ext_ok_o (ext_ok_o)
);

// File: tb/tick_source_sel_bench.sv
`timescale 1ns/1ps
module tick_source_sel_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] wd = '0;
  logic [3:0] rd;
  logic       ext = 1'b0, osc = 1'b0, bx = 1'b0, bx_en = 1'b0;
  logic [1:0] ratio = 2'b00;
  logic       tick, ok;
  logic [1:0] src;

  always #2 clk = ~clk;

  tick_source_sel u_tick_source_sel (
    .clk_i (clk), .rst_ni (rst_n), .ctrl_we_i (we), .ctrl_wdata_i (wd),
    .ctrl_rdata_o (rd), .ext_clk_i (ext), .osc_clk_i (osc),
    .psc_ratio_i (ratio), .bx_i (bx), .bx_clr_en_i (bx_en),
    .tick_o (tick), .src_o (src), .ext_ok_o (ok)
  );

  typedef struct {
    string tag;
    int    ticks;
    int    src;
    int    ok;
    int    rd;
  } item_t;

  item_t sb[$];
  int checks = 0, errors = 0, tick_cnt = 0;

  // Monitor: count ticks, pop and compare expectations
  always @(negedge clk) begin
    if (rst_n && tick) tick_cnt++;
    if (sb.size() > 0) begin
      item_t it;
      bit bad;
      it = sb.pop_front();
      bad = 0;
      checks++;
      if (tick_cnt != it.ticks) begin
        bad = 1;
        $display("FAIL %s ticks actual %0d expected %0d", it.tag, tick_cnt, it.ticks);
      end
      if (it.src >= 0 && int'(src) != it.src) begin
        bad = 1;
        $display("FAIL %s src actual %0d expected %0d", it.tag, src, it.src);
      end
      if (it.ok >= 0 && int'(ok) != it.ok) begin
        bad = 1;
        $display("FAIL %s ext_ok actual %0d expected %0d", it.tag, ok, it.ok);
      end
      if (it.rd >= 0 && int'(rd) != it.rd) begin
        bad = 1;
        $display("FAIL %s rdata actual %0h expected %0h", it.tag, rd, it.rd);
      end
      if (bad) errors++;
      tick_cnt = 0;
    end
  end

  task automatic expect_item(input string tag, input int t, input int s,
                             input int k, input int r);
    item_t it;
    repeat (6) @(negedge clk);
    @(posedge clk); #1;
    it.tag = tag; it.ticks = t; it.src = s; it.ok = k; it.rd = r;
    sb.push_back(it);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] v);
    @(negedge clk); we = 1'b1; wd = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext = 1'b1; repeat (3) @(negedge clk);
      ext = 1'b0; repeat (2) @(negedge clk);
    end
  endtask

  task automatic osc_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc = 1'b1; repeat (3) @(negedge clk);
      osc = 1'b0; repeat (2) @(negedge clk);
    end
  endtask

  task automatic bx_pulse();
    @(negedge clk); bx = 1'b1; repeat (3) @(negedge clk);
    bx = 1'b0; repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_item("R1 reset held", 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    expect_item("R1 after release", 0, 0, 0, 0);

    // R3 / R2: step source, only 0->1 writes advance
    wr(4'b0000); wr(4'b1000); wr(4'b1000); wr(4'b1100); wr(4'b0000); wr(4'b1000);
    expect_item("R3 step writes", 2, 0, -1, 4'b1000);

    // R4: oscillator source
    wr(4'b0001); osc_pulses(5);
    expect_item("R4 osc ticks", 5, 1, -1, 4'b0001);
    ext_pulses(3);
    expect_item("R4 ext ignored", 0, 1, -1, 4'b0001);

    // R5: external source
    wr(4'b0010); bx_en = 1'b1; bx_pulse(); ext_pulses(6);
    expect_item("R5 ext ticks", 6, 2, -1, 4'b0010);
    osc_pulses(4);
    expect_item("R5 osc ignored", 0, 2, -1, 4'b0010);

    // R6: divider ratios from a cleared count
    ratio = 2'b01; bx_pulse(); ext_pulses(8);
    expect_item("R6 divide by 2", 4, 2, -1, -1);
    ratio = 2'b10; bx_pulse(); ext_pulses(8);
    expect_item("R6 divide by 4", 2, 2, -1, -1);

    // R7: beam-crossing clear restarts the divider, ignored when disabled
    bx_pulse(); ext_pulses(2); bx_pulse(); ext_pulses(3);
    expect_item("R7 clear restarts", 0, 2, -1, -1);
    bx_en = 1'b0; bx_pulse(); ext_pulses(1);
    expect_item("R7 clear disabled", 1, 2, -1, -1);

    // R8: falling-edge counting
    ratio = 2'b00; wr(4'b0110);
    @(negedge clk); ext = 1'b1;
    expect_item("R8 rise not counted", 0, 2, -1, 4'b0110);
    @(negedge clk); ext = 1'b0;
    expect_item("R8 fall counted", 1, 2, -1, 4'b0110);

    // R9 / R10: automatic failover
    wr(4'b0010); wr(4'b0011); repeat (24) @(negedge clk);
    expect_item("R10 ext judged idle", 0, 1, 0, 4'b0011);
    osc_pulses(3);
    expect_item("R9 fallback on osc", 3, 1, 0, 4'b0011);
    ext_pulses(6);
    expect_item("R9 R10 ext revived", 2, 2, 1, 4'b0011);
    repeat (20) @(negedge clk);
    expect_item("R10 ext failed", 0, 1, 0, 4'b0011);
    osc_pulses(2);
    expect_item("R9 back on osc", 2, 1, 0, 4'b0011);
    ext_pulses(3); repeat (20) @(negedge clk); ext_pulses(3);
    expect_item("R10 broken run no revive", 0, 1, 0, 4'b0011);

    repeat (4) @(negedge clk);
    summary();
  end

endmodule